// File: doc/BRIEF.md
# Chip-Select Serial Readout for a 16-bit SAR Converter

This block is the digital front of a successive-approximation converter in a four-wire mode with chip select and no busy signal. A host raises the convert line while its select line (SDI) is high. That starts a conversion of fixed length, counted in system clocks. At the end of the count the converter's result word is captured, and the block waits in acquisition. The host reads the word by pulling SDI low, which drives the most significant bit onto the serial output. Each falling serial-clock edge then advances one bit.

The output pin is modelled as a data bit plus an enable. The output is released after the sixteenth falling clock edge, or as soon as SDI returns high, whichever comes first. With both the convert line and SDI low, the pin is actively held low. If SDI is low late in the conversion window, the block raises a protocol-error flag, because that pattern would request a busy indication that this mode does not give. All three host inputs are brought through two-flop synchronizers, and edges are found on the synchronized copies.

Top module: `sar_cs_port`

## Requirements
- R1: After reset, with the convert line low and SDI high, the output enable is low, the conversion indicator is low and the protocol-error flag is low.
- R2: A rising convert edge while SDI is high starts a conversion. The conversion indicator is high for CONV_CYCLES system clocks and the output enable stays low.
- R3: A rising convert edge while SDI is low starts no conversion. The conversion indicator stays low.
- R4: While the convert line and SDI are both low, the output enable is high and the output bit is 0.
- R5: The result word is captured in the last cycle of the conversion. Changes to the result input after that point do not affect the word that is read.
- R6: In acquisition, with the convert line high, SDI low enables the output and presents result bit 15.
- R7: Each synchronized falling serial-clock edge during a read presents the next lower bit, most significant first.
- R8: The output enable falls after the 16th falling serial-clock edge. Further clock edges in the same cycle of the convert line do not enable it again.
- R9: SDI returning high during a read disables the output before all 16 bits have been shifted.
- R10: SDI low during the conversion phase does not enable the output.
- R11: SDI seen low when the conversion count is CONV_MIN or higher sets the protocol-error flag. The flag holds until the next conversion starts. SDI low that returns high before CONV_MIN leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cnvIn | input | 1 | Convert line from the host, asynchronous |
| sdiIn | input | 1 | Select line from the host, asynchronous |
| sckIn | input | 1 | Serial clock from the host, asynchronous |
| resultIn | input | DATA_W | Result word from the converter model |
| sdoOut | output | 1 | Serial data bit |
| sdoEn | output | 1 | Output enable; low means the pin floats |
| convPhase | output | 1 | High during conversion, low in acquisition |
| protoErr | output | 1 | Late-SDI protocol error, cleared at conversion start |

## Verification
A table of result words is read back through full 16-bit reads and through reads cut short after one and after five bits. The all-ones, all-zeros and alternating patterns show whether bit order and shifting are correct, and the short reads show that release on SDI high is kept apart from release on the bit count. Directed cases keep apart the things that look alike at the pin: the output driven low with both lines low, the output floating with SDI low during conversion, a convert edge with SDI low that is ignored, and a result word that changes before or after the capture point. The protocol-error flag is tried with SDI low early in the conversion window and with SDI low late in it.

// File: rtl/sar_cs_pkg.sv
package sar_cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_ACQ,
    ST_READ,
    ST_DONE
  } phase_t;

  typedef struct packed {
    logic load;      // capture result word
    logic shift;     // advance one bit
    logic drive;     // read in progress, present shift MSB
    logic forceLow;  // both lines low, hold pin low
  } strobe_t;

endpackage

// File: rtl/sar_cs_sync.sv
module sar_cs_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[s] <= '0;
          else       pipe[s] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[s] <= '0;
          else       pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/sar_cs_ctrl.sv
module sar_cs_ctrl
  import sar_cs_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 40,
  parameter int CONV_MIN    = 24
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cnvS,
  input  logic    sdiS,
  input  logic    sckS,
  output strobe_t strobes,
  output logic    convPhase,
  output logic    protoErr
);

  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam int BIT_W = $clog2(DATA_W + 1);

  phase_t             state, nextState;
  logic               cnvD, sckD;
  logic [CNT_W-1:0]   convCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic               cnvRise, sckFall, convLast, lastBit, startConv;

  assign cnvRise   = cnvS & ~cnvD;
  assign sckFall   = ~sckS & sckD;
  assign convLast  = (convCnt == CNT_W'(CONV_CYCLES - 1));
  assign lastBit   = (bitCnt == BIT_W'(DATA_W - 1));
  assign startConv = (state == ST_IDLE) && cnvRise && sdiS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnvD <= 1'b0;
      sckD <= 1'b0;
    end else begin
      cnvD <= cnvS;
      sckD <= sckS;
    end
  end

  always_comb begin
    nextState = state;
    if (!cnvS) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (startConv) nextState = ST_CONV;
        ST_CONV: if (convLast) nextState = ST_ACQ;
        ST_ACQ:  if (!sdiS) nextState = ST_READ;
        ST_READ: begin
          if (sdiS)                  nextState = ST_DONE;
          else if (sckFall && lastBit) nextState = ST_DONE;
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) convCnt <= '0;
    else if (state != ST_CONV) convCnt <= '0;
    else convCnt <= convCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (state != ST_READ) bitCnt <= '0;
    else if (sckFall) bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) protoErr <= 1'b0;
    else if (startConv) protoErr <= 1'b0;
    else if (state == ST_CONV && !sdiS && convCnt >= CNT_W'(CONV_MIN))
      protoErr <= 1'b1;
  end

  always_comb begin
    strobes          = '0;
    strobes.load     = (state == ST_CONV) && convLast && cnvS;
    strobes.shift    = (state == ST_READ) && sckFall && !sdiS && cnvS;
    strobes.drive    = (state == ST_READ);
    strobes.forceLow = !cnvS && !sdiS;
  end

  assign convPhase = (state == ST_CONV);

  // R2: convert edge with select high enters conversion
  assert_conv_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cnvRise && sdiS) |=> convPhase);

  // R3: convert edge with select low leaves conversion off
  assert_no_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cnvRise && !sdiS) |=> !convPhase);

  // R8: sixteenth falling edge ends the read
  assert_read_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && cnvS && !sdiS && sckFall && lastBit) |=> (state == ST_DONE));

  // R11: late select low flags an error
  assert_late_sdi_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && cnvS && !sdiS && convCnt >= CNT_W'(CONV_MIN)) |=> protoErr);

endmodule

// File: rtl/sar_cs_datapath.sv
module sar_cs_datapath
  import sar_cs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] resultIn,
  output logic              sdoOut,
  output logic              sdoEn
);

  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobes.load) shiftReg <= resultIn;
    else if (strobes.shift) shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
  end

  assign sdoEn  = strobes.drive | strobes.forceLow;
  assign sdoOut = strobes.drive & shiftReg[DATA_W-1];

  // R5: capture takes the result input of that cycle
  assert_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (shiftReg == $past(resultIn)));

  // R7: each shift moves the next lower bit to the top
  assert_shift_order_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shift && !strobes.load) |=> (shiftReg[DATA_W-1] == $past(shiftReg[DATA_W-2])));

endmodule

// File: rtl/sar_cs_port.sv
module sar_cs_port
  import sar_cs_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 40,
  parameter int CONV_MIN    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cnvIn,
  input  logic              sdiIn,
  input  logic              sckIn,
  input  logic [DATA_W-1:0] resultIn,
  output logic              sdoOut,
  output logic              sdoEn,
  output logic              convPhase,
  output logic              protoErr
);

  logic [2:0] syncVec;
  logic       cnvSync, sdiSync, sckSync;
  strobe_t    strobes;

  sar_cs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({cnvIn, sdiIn, sckIn}),
    .syncOut (syncVec)
  );

  assign {cnvSync, sdiSync, sckSync} = syncVec;

  sar_cs_ctrl #(
    .DATA_W      (DATA_W),
    .CONV_CYCLES (CONV_CYCLES),
    .CONV_MIN    (CONV_MIN)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cnvS      (cnvSync),
    .sdiS      (sdiSync),
    .sckS      (sckSync),
    .strobes   (strobes),
    .convPhase (convPhase),
    .protoErr  (protoErr)
  );

  sar_cs_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .resultIn (resultIn),
    .sdoOut   (sdoOut),
    .sdoEn    (sdoEn)
  );

  // R10: no output drive while converting with the convert line high
  assert_quiet_conv_R10: assert property (@(posedge clk) disable iff (!rstN)
    (convPhase && cnvSync) |-> !sdoEn);

  // R4: both lines low holds the pin low
  assert_force_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!cnvSync && !sdiSync) |-> (sdoEn && !sdoOut));

endmodule

// File: tb/sar_cs_port_test.sv
`timescale 1ns/1ps
module sar_cs_port_test;

  localparam int DATA_W = 16;
  localparam int CONV_CYCLES = 40;
  localparam int NVEC = 5;
  localparam logic [15:0] VEC_DATA [NVEC] = '{16'hA5C3, 16'hFFFF, 16'h0000, 16'h8001, 16'h1234};
  localparam int          VEC_BITS [NVEC] = '{16, 16, 16, 5, 1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cnvIn = 1'b0, sdiIn = 1'b1, sckIn = 1'b0;
  logic [DATA_W-1:0] resultIn = '0;
  logic sdoOut, sdoEn, convPhase, protoErr;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sar_cs_port uut (
    .clk(clk), .rstN(rstN), .cnvIn(cnvIn), .sdiIn(sdiIn), .sckIn(sckIn),
    .resultIn(resultIn), .sdoOut(sdoOut), .sdoEn(sdoEn),
    .convPhase(convPhase), .protoErr(protoErr)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic startConv();
    sdiIn = 1'b1;
    cnvIn = 1'b1;
    tick(6);
    check(convPhase, 1, "R2 conversion indicator");
    check(sdoEn, 0, "R2 output floats in conversion");
  endtask

  task automatic finishConv();
    tick(CONV_CYCLES);
    check(convPhase, 0, "R2 conversion ends");
  endtask

  task automatic sckPulse();
    sckIn = 1'b1;
    tick(5);
    sckIn = 1'b0;
    tick(5);
  endtask

  task automatic endCycle();
    sdiIn = 1'b1;
    tick(2);
    cnvIn = 1'b0;
    tick(6);
  endtask

  task automatic readWord(input logic [15:0] exp, input int nBits);
    sdiIn = 1'b0;
    tick(5);
    check(sdoEn, 1, "R6 enable on select low");
    check(sdoOut, exp[15], "R6 MSB first");
    for (int i = 1; i <= nBits; i++) begin
      sckPulse();
      if (i < 16) begin
        check(sdoEn, 1, "R7 enable during read");
        check(sdoOut, exp[15-i], "R7 bit order");
      end else begin
        check(sdoEn, 0, "R8 release after last edge");
      end
    end
    if (nBits < 16) begin
      sdiIn = 1'b1;
      tick(5);
      check(sdoEn, 0, "R9 release on select high");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(4);
    rstN = 1'b1;
    tick(6);
    // R1 reset state
    check(sdoEn, 0, "R1 enable after reset");
    check(convPhase, 0, "R1 phase after reset");
    check(protoErr, 0, "R1 error after reset");

    // table walk: R2, R6, R7, R8, R9
    for (int v = 0; v < NVEC; v++) begin
      resultIn = VEC_DATA[v];
      startConv();
      finishConv();
      readWord(VEC_DATA[v], VEC_BITS[v]);
      endCycle();
    end

    // R4 both lines low drive the pin low
    sdiIn = 1'b0;
    tick(5);
    check(sdoEn, 1, "R4 enable with both low");
    check(sdoOut, 0, "R4 pin low");

    // R3 convert edge with select low
    cnvIn = 1'b1;
    tick(6);
    check(convPhase, 0, "R3 no conversion");
    check(sdoEn, 0, "R3 output floats");
    tick(CONV_CYCLES);
    check(convPhase, 0, "R3 still idle");
    endCycle();

    // R5 capture point
    resultIn = 16'h3C5A;
    startConv();
    resultIn = 16'hC381;
    finishConv();
    resultIn = 16'h0F0F;
    readWord(16'hC381, 16);
    // R8 extra edges do nothing
    for (int k = 0; k < 3; k++) begin
      sckPulse();
      check(sdoEn, 0, "R8 no re-enable");
    end
    endCycle();

    // R10 and R11 negative: early select low
    resultIn = 16'h5555;
    startConv();
    sdiIn = 1'b0;
    tick(4);
    check(sdoEn, 0, "R10 no drive in conversion");
    check(convPhase, 1, "R10 still converting");
    sdiIn = 1'b1;
    tick(CONV_CYCLES);
    check(protoErr, 0, "R11 early select low no error");
    readWord(16'h5555, 16);
    endCycle();

    // R11 late select low
    resultIn = 16'h9ABC;
    startConv();
    tick(24);
    sdiIn = 1'b0;
    tick(6);
    check(protoErr, 1, "R11 late select low error");
    check(sdoEn, 0, "R10 no drive late in conversion");
    tick(20);
    check(protoErr, 1, "R11 error holds");
    check(sdoEn, 1, "R6 read after late select");
    check(sdoOut, 1, "R6 MSB after late select");
    endCycle();
    startConv();
    check(protoErr, 0, "R11 cleared at next start");
    finishConv();
    endCycle();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule